// File: doc/BRIEF.md
# Relative Conditional Branch Resolver

This block settles the outcome of a long-reach relative branch that is gated by a condition mask. A pulse on `in_valid` brings in four values: the address of the branch instruction, a 4-bit condition mask, a 32-bit signed count of halfwords, and the 2-bit condition code that is live at that moment. The block decides whether the branch is taken. It forms the relative target from the instruction's own address and the doubled offset, and it forms the sequential address that follows the 6-byte instruction. It then returns the chosen next address with a taken flag.

Each cycle one instruction can be accepted. The result comes back through a single registered stage, so a branch unit in a fetch pipeline can place the block directly after decode. Fetch, decode, updating the condition code, flushing and exceptions are handled elsewhere.

Top module: `relbr_resolver`

## Requirements
- R1: The condition code selects one mask bit. Code 0 selects `in_mask[3]`, code 1 selects `in_mask[2]`, code 2 selects `in_mask[1]` and code 3 selects `in_mask[0]`. The branch is taken exactly when the selected bit is 1.
- R2: A mask of 4'b0000 never takes the branch, whatever the condition code.
- R3: A mask of 4'b1111 always takes the branch, whatever the condition code.
- R4: When the branch is taken, `out_next_addr` equals `in_addr` plus twice the sign-extended `in_offset`. For example, an offset of -1 gives `in_addr - 2`, and an offset of 32'h7FFFFFFF gives `in_addr + 2^32 - 2`.
- R5: When the branch is not taken, `out_next_addr` equals `in_addr + 6`.
- R6: Both address sums wrap modulo 2^ADDR_W. No error indication is raised.
- R7: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and low otherwise. A synchronous active-high `rst` clears `out_valid`, `out_taken` and `out_next_addr` to 0.
- R8: In a cycle with `in_valid` low, the mask, offset, code and address inputs have no effect. `out_taken` and `out_next_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A branch is presented this cycle |
| in_addr | input | ADDR_W (64) | Address of the branch instruction |
| in_mask | input | 4 | Condition mask; the MSB matches code 0 |
| in_offset | input | OFF_W (32) | Signed offset, counted in halfwords |
| in_cc | input | 2 | Current condition code |
| out_valid | output | 1 | Result valid, one cycle after input |
| out_taken | output | 1 | The branch was taken |
| out_next_addr | output | ADDR_W (64) | Target if taken, else address + 6 |

## Verification
The block holds only its output register, so a faulty decision or sum shows at the ports in the cycle straight after the pulse that caused it. A mask-bit mapping that is reversed or shifted shows as a wrong `out_taken` for some mask and code pair. For that reason all 64 pairs are applied. An error in the sign extension or the doubling shows in the address only for negative or extreme offsets. The -1, maximum and minimum offsets, together with a case that wraps near the top of the address space, expose such errors in one vector each. If the register is loaded on idle cycles, that shows as a change in the held outputs while `in_valid` is low.

// File: rtl/relbr_pkg.sv
package relbr_pkg;
  localparam int CC_W   = 2;
  localparam int NCODES = 1 << CC_W;
  localparam int MASK_W = NCODES;

  typedef logic [CC_W-1:0]   cc_t;
  typedef logic [MASK_W-1:0] mask_t;
endpackage

// File: rtl/relbr_cond_eval.sv
module relbr_cond_eval
  import relbr_pkg::*;
(
  input  mask_t mask,
  input  cc_t   cc,
  output logic  take
);
  // One match line per condition code; mask MSB pairs with code 0.
  logic [NCODES-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NCODES; g++) begin : g_code
      assign hit[g] = (cc == cc_t'(g)) & mask[MASK_W-1-g];
    end
  endgenerate

  assign take = |hit;
endmodule

// File: rtl/relbr_addr_gen.sv
module relbr_addr_gen #(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int INSN_BYTES = 6
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] seq
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] off_bytes;

  generate
    if (EXT_W > 0) begin : g_extend
      assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[ADDR_W-1:0];
    end
  endgenerate

  // Halfwords to bytes; the sum wraps naturally at ADDR_W bits.
  assign off_bytes = {off_ext[ADDR_W-2:0], 1'b0};
  assign target    = base + off_bytes;
  assign seq       = base + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/relbr_resolver.sv
module relbr_resolver #(
  parameter int ADDR_W     = 64,
  parameter int OFF_W      = 32,
  parameter int INSN_BYTES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [3:0]        in_mask,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [1:0]        in_cc,
  output logic              out_valid,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_next_addr
);
  import relbr_pkg::*;

  logic              take_c;
  logic [ADDR_W-1:0] tgt_c;
  logic [ADDR_W-1:0] seq_c;

  relbr_cond_eval u_cond (
    .mask (mask_t'(in_mask)),
    .cc   (cc_t'(in_cc)),
    .take (take_c)
  );

  relbr_addr_gen #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .INSN_BYTES (INSN_BYTES)
  ) u_addr (
    .base   (in_addr),
    .offset (in_offset),
    .target (tgt_c),
    .seq    (seq_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_taken     <= 1'b0;
      out_next_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken     <= take_c;
        out_next_addr <= take_c ? tgt_c : seq_c;
      end
    end
  end

  // R1: registered decision follows the mask bit picked by the code
  assert_mask_select_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_taken == $past(in_mask[2'd3 - in_cc]));

  // R2: empty mask never branches
  assert_never_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mask == 4'h0) |=> !out_taken);

  // R3: full mask always branches
  assert_always_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mask == 4'hF) |=> out_taken);

  // R5: fall-through address when not taken
  assert_seq_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mask == 4'h0) |=>
      out_next_addr == $past(in_addr) + ADDR_W'(INSN_BYTES));

  // R7: one-cycle latency, no spurious results
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_extra_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R8: idle cycles leave the result alone
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_taken) && $stable(out_next_addr)));
endmodule

// File: tb/relbr_resolver_bench.sv
module relbr_resolver_bench;
  localparam int AW = 64;
  localparam int OW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [3:0]    in_mask = '0;
  logic [OW-1:0] in_offset = '0;
  logic [1:0]    in_cc = '0;
  logic          out_valid;
  logic          out_taken;
  logic [AW-1:0] out_next_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  relbr_resolver u_relbr_resolver (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
    .in_mask(in_mask), .in_offset(in_offset), .in_cc(in_cc),
    .out_valid(out_valid), .out_taken(out_taken), .out_next_addr(out_next_addr)
  );

  function automatic bit ref_take(logic [3:0] m, logic [1:0] c);
    return m[3 - int'(c)];
  endfunction

  function automatic logic [AW-1:0] ref_next(logic [AW-1:0] a, logic [3:0] m,
                                             logic [OW-1:0] o, logic [1:0] c);
    longint signed d;
    d = longint'($signed(o)) * 2;
    if (ref_take(m, c)) return a + AW'(d);
    return a + 64'd6;
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at negedge, check at the following negedge (after one posedge).
  task automatic apply(logic [AW-1:0] a, logic [3:0] m, logic [OW-1:0] o,
                       logic [1:0] c, string req);
    in_valid = 1'b1; in_addr = a; in_mask = m; in_offset = o; in_cc = c;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, "/R7 valid"}, AW'(out_valid), 64'd1);
    check({req, " taken"}, AW'(out_taken), AW'(ref_take(m, c)));
    check({req, " next"}, out_next_addr, ref_next(a, m, o, c));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ha;
    logic          ht;
    void'($urandom(32'hC0DE));
    repeat (3) @(negedge clk);
    check("R7 reset valid", AW'(out_valid), 64'd0);
    check("R7 reset taken", AW'(out_taken), 64'd0);
    check("R7 reset addr", out_next_addr, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R5: every mask against every code
    for (int m = 0; m < 16; m++)
      for (int c = 0; c < 4; c++)
        apply(64'h0000_1234_5678_0000, 4'(m), 32'h0000_0100, 2'(c),
              m == 0 ? "R2" : (m == 15 ? "R3" : "R1"));

    // R4: offset corners
    apply(64'h0000_0000_8000_0000, 4'hF, 32'h0000_0000, 2'd1, "R4 zero");
    apply(64'h0000_0000_8000_0000, 4'hF, 32'h0000_0001, 2'd2, "R4 plus1");
    apply(64'h0000_0000_8000_0000, 4'hF, 32'hFFFF_FFFF, 2'd3, "R4 minus1");
    apply(64'h0000_0000_8000_0000, 4'h8, 32'h7FFF_FFFF, 2'd0, "R4 maxpos");
    apply(64'h0000_0010_0000_0000, 4'h8, 32'h8000_0000, 2'd0, "R4 maxneg");

    // R6: wrap in both directions
    apply(64'hFFFF_FFFF_FFFF_FFFC, 4'hF, 32'h0000_0010, 2'd0, "R6 wrap up");
    apply(64'h0000_0000_0000_0004, 4'hF, 32'h8000_0000, 2'd0, "R6 wrap down");
    apply(64'hFFFF_FFFF_FFFF_FFFE, 4'h0, 32'h0000_0000, 2'd0, "R6 seq wrap");

    // R8: idle cycles with toggling inputs leave the result untouched
    apply(64'h0000_0000_0000_4000, 4'h7, 32'h0000_0020, 2'd1, "R8 setup");
    ha = out_next_addr; ht = out_taken;
    in_addr = 64'hDEAD_BEEF_0000_0000; in_mask = 4'hF; in_offset = 32'h1234; in_cc = 2'd2;
    @(negedge clk);
    check("R8/R7 idle valid", AW'(out_valid), 64'd0);
    check("R8 idle taken", AW'(out_taken), AW'(ht));
    check("R8 idle addr", out_next_addr, ha);
    in_mask = 4'h0;
    @(negedge clk);
    check("R8 idle addr2", out_next_addr, ha);

    // Random mix
    for (int i = 0; i < 400; i++)
      apply({$urandom, $urandom}, 4'($urandom), $urandom, 2'($urandom), "rand R1/R4/R5");

    // R7: back-to-back pulses
    in_valid = 1'b1; in_addr = 64'h100; in_mask = 4'h8; in_offset = 32'd4; in_cc = 2'd0;
    @(negedge clk);
    check("R7 b2b1", out_next_addr, 64'h108);
    in_cc = 2'd1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 b2b2", out_next_addr, 64'h106);
    check("R7 b2b valid", AW'(out_valid), 64'd1);

    // R7: reset clears again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R7 rerst", AW'(out_valid) | AW'(out_taken) | out_next_addr, 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule